// File: doc/BRIEF.md
# Adaptive supply reference selector

This controller searches upward for the lowest supply reference at which a group of replica delay paths, standing in for the slowest logic on the die, still meet timing. It runs in rounds of three clock cycles. In the first cycle it strobes a test transition into the replicas. In the second it reads the replica results and decides. In the third it strobes a clear so that the replicas and the timing checker start the next round from a known low state.

A round counts as passing only when every replica result is high. If any replica is late, the reference code moves up one 50 mV step. It stops at the top level and goes no higher. If the round passes, the code holds and a lock flag goes high. The lock flag then stays high until reset, even if later rounds fail and push the code higher. The code feeds an external reference DAC. The replica paths and the DAC are analog and sit outside this block.

Top module: `vref_search_ctrl`

## Requirements
- R1: Rounds repeat as launch, check, clear, one clock cycle each. `launch_o` is high only in the launch cycle and `clear_o` only in the clear cycle. The first cycle after reset release is a launch cycle.
- R2: If a check cycle fails and the code is below its top value, `level_o` is one higher from the following clear cycle on.
- R3: While in reset and right after it, `level_o` is 0 (350 mV) and `locked_o` is 0.
- R4: The code maps 00→350 mV, 01→400 mV, 10→450 mV, 11→500 mV. At 11 a failing round leaves the code at 11.
- R5: A check passes only when every bit of `path_ok_i` is 1. A single low bit counts as a failure.
- R6: A passing check leaves `level_o` unchanged and sets `locked_o` from the following clear cycle on. `locked_o` then stays 1 until reset.
- R7: `level_o` changes only on the clock edge that ends a check cycle.
- R8: `path_ok_i` is ignored during launch and clear cycles. Its value there affects neither `level_o` nor `locked_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| path_ok_i | input | N_PATHS | Per-replica timing results, 1 = settled in time |
| launch_o | output | 1 | Strobe that starts the test transition |
| clear_o | output | 1 | Strobe that clears the replicas and the checker |
| level_o | output | CODE_W | Reference code for the DAC |
| locked_o | output | 1 | High once any round has passed |

## Verification
A phase counter that slips shows up at `launch_o` and `clear_o` within one cycle. It also makes the code move on an edge outside the check phase, which the bench sees at the next sample. A wrong step or a wrong saturation rule shows on `level_o` in the clear cycle of the round that decided it. A bad combine of the replica results shows as a climb where the code should hold, or a hold where it should climb, within one round. The bench also drives the inverse of the replica results in the non-check cycles, so any sampling outside the check cycle shows as a code different from the model's.

// File: rtl/vref_pkg.sv
package vref_pkg;

  typedef enum logic [1:0] {
    PH_LAUNCH = 2'd0,
    PH_CHECK  = 2'd1,
    PH_CLEAR  = 2'd2
  } phase_e;

  function automatic phase_e phase_after(phase_e ph);
    case (ph)
      PH_LAUNCH: return PH_CHECK;
      PH_CHECK:  return PH_CLEAR;
      default:   return PH_LAUNCH;
    endcase
  endfunction

endpackage

// File: rtl/vref_round_seq.sv
module vref_round_seq
  import vref_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o,
  output logic   launch_o,
  output logic   check_o,
  output logic   clear_o
);

  phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_LAUNCH;
    else        phase_q <= phase_after(phase_q);
  end

  assign phase_o  = phase_q;
  assign launch_o = (phase_q == PH_LAUNCH);
  assign check_o  = (phase_q == PH_CHECK);
  assign clear_o  = (phase_q == PH_CLEAR);

endmodule

// File: rtl/vref_path_combiner.sv
module vref_path_combiner #(
  parameter int N_PATHS = 4
) (
  input  logic [N_PATHS-1:0] path_ok_i,
  output logic               all_ok_o
);

  always_comb begin
    all_ok_o = 1'b1;
    for (int i = 0; i < N_PATHS; i++) begin
      all_ok_o = all_ok_o & path_ok_i[i];
    end
  end

endmodule

// File: rtl/vref_level_reg.sv
module vref_level_reg #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decide_i,
  input  logic              pass_i,
  output logic [CODE_W-1:0] level_o,
  output logic              locked_o
);

  localparam logic [CODE_W-1:0] LVL_TOP = {CODE_W{1'b1}};

  function automatic logic [CODE_W-1:0] level_step(logic [CODE_W-1:0] lv, logic ok);
    if (ok || lv == LVL_TOP) return lv;
    return lv + CODE_W'(1);
  endfunction

  logic [CODE_W-1:0] level_q;
  logic              locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      locked_q <= 1'b0;
    end else if (decide_i) begin
      level_q <= level_step(level_q, pass_i);
      if (pass_i) locked_q <= 1'b1;
    end
  end

  assign level_o  = level_q;
  assign locked_o = locked_q;

endmodule

// File: rtl/vref_search_ctrl.sv
module vref_search_ctrl
  import vref_pkg::*;
#(
  parameter int N_PATHS = 4,
  parameter int CODE_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PATHS-1:0] path_ok_i,
  output logic               launch_o,
  output logic               clear_o,
  output logic [CODE_W-1:0]  level_o,
  output logic               locked_o
);

  phase_e phase;
  logic   in_check;
  logic   all_ok;

  vref_round_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_o  (phase),
    .launch_o (launch_o),
    .check_o  (in_check),
    .clear_o  (clear_o)
  );

  vref_path_combiner #(.N_PATHS(N_PATHS)) u_comb (
    .path_ok_i (path_ok_i),
    .all_ok_o  (all_ok)
  );

  vref_level_reg #(.CODE_W(CODE_W)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .decide_i (in_check),
    .pass_i   (all_ok),
    .level_o  (level_o),
    .locked_o (locked_o)
  );

endmodule

// File: rtl/vref_search_chk.sv
module vref_search_chk #(
  parameter int N_PATHS = 4,
  parameter int CODE_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               launch,
  input logic               in_check,
  input logic               clear,
  input logic [N_PATHS-1:0] path_ok,
  input logic [CODE_W-1:0]  level,
  input logic               locked
);

  localparam logic [CODE_W-1:0] LVL_TOP = {CODE_W{1'b1}};

  // R1
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({launch, in_check, clear}) == 1);

  // R1
  launch_then_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> in_check);

  // R1
  check_then_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_check |=> clear);

  // R2
  fail_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && !(&path_ok) && level != LVL_TOP) |=> level == CODE_W'($past(level) + CODE_W'(1)));

  // R4
  top_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && level == LVL_TOP) |=> level == LVL_TOP);

  // R6
  pass_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && (&path_ok)) |=> (locked && $stable(level)));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R7
  level_moves_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_check |=> $stable(level));

endmodule

bind vref_search_ctrl vref_search_chk #(.N_PATHS(N_PATHS), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .launch   (launch_o),
  .in_check (in_check),
  .clear    (clear_o),
  .path_ok  (path_ok_i),
  .level    (level_o),
  .locked   (locked_o)
);

// File: tb/test_vref_search_ctrl.sv
module test_vref_search_ctrl;
  localparam int N = 4;
  localparam int W = 2;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [N-1:0] path_ok = '0;
  logic         launch_o, clear_o, locked_o;
  logic [W-1:0] level_o;

  vref_search_ctrl #(.N_PATHS(N), .CODE_W(W)) i_vref_search_ctrl (
    .clk(clk), .rst_n(rst_n), .path_ok_i(path_ok),
    .launch_o(launch_o), .clear_o(clear_o), .level_o(level_o), .locked_o(locked_o)
  );

  int total = 0, bad = 0;
  int thr = 0;
  logic [N-1:0] stuck = '0, partial = '0;
  bit scramble = 0;
  int m_ph = 0, m_lvl = 0;
  bit m_lock = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_lvl = 0; m_lock = 0;
    end else begin
      if (m_ph == 1) begin
        if (path_ok == {N{1'b1}}) m_lock = 1;
        else if (m_lvl < TOP) m_lvl = m_lvl + 1;
      end
      m_ph = (m_ph + 1) % 3;
    end
  end

  // compare, then drive the replica model for the coming cycle
  always @(negedge clk) begin
    logic [N-1:0] b;
    if (rst_n && !done) begin
      chk("R1 launch", int'(launch_o), int'(m_ph == 0));
      chk("R1 clear", int'(clear_o), int'(m_ph == 2));
      chk("R7 level", int'(level_o), m_lvl);
      chk("R6 locked", int'(locked_o), int'(m_lock));
    end
    b = (int'(level_o) >= thr) ? ~stuck : partial;
    if (scramble && m_ph != 1) b = ~b;
    path_ok = b;
  end

  task automatic scen(int t, logic [N-1:0] st, logic [N-1:0] pa, bit scr, int ncyc);
    @(negedge clk);
    rst_n = 1'b0;
    thr = t; stuck = st; partial = pa; scramble = scr;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 reset level", int'(level_o), 0);
    chk("R3 reset locked", int'(locked_o), 0);
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R6: passes at once, code holds at 350 mV
    scen(0, '0, 4'b0111, 0, 30);
    chk("R6 hold level", int'(level_o), 0);
    chk("R6 locked", int'(locked_o), 1);
    // R2: climbs to 450 mV (code 10) and locks
    scen(2, '0, 4'b1101, 0, 30);
    chk("R2 climb level", int'(level_o), 2);
    chk("R2 locked", int'(locked_o), 1);
    // R4: never passes, saturates at code 11
    scen(9, '0, 4'b1110, 0, 40);
    chk("R4 cap level", int'(level_o), 3);
    chk("R4 not locked", int'(locked_o), 0);
    // R5: one replica stuck low, never passes
    scen(0, 4'b0100, 4'b1011, 0, 40);
    chk("R5 single lane fails level", int'(level_o), 3);
    chk("R5 not locked", int'(locked_o), 0);
    // R8: inverted results outside the check cycle are ignored
    scen(2, '0, 4'b1011, 1, 40);
    chk("R8 level", int'(level_o), 2);
    chk("R8 locked", int'(locked_o), 1);
    // R6: lock stays after later failures push the code up
    scen(1, '0, 4'b0011, 0, 20);
    chk("R6 first lock level", int'(level_o), 1);
    thr = 9;
    repeat (30) @(negedge clk);
    chk("R6 sticky locked", int'(locked_o), 1);
    chk("R4 cap after lock", int'(level_o), 3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule